// File: doc/BRIEF.md
# PHY Link Status Poller

This block runs in the background beside an Ethernet MAC array and keeps track of link state without any help from software. Once it is enabled, it walks a programmable window of PHY addresses. For each address it issues three management reads through a simple request/response port to an external MDIO serialiser. From those reads it works out link, duplex and speed, and it stores the result as a status word for the matching port.

Each port also has a control word. The control word can force the port's status to fixed values that replace the polled result, and it drives the port's MAC enables and flow-control enables. When the link bit of a port's status word changes, the block latches a sticky change bit. Software clears a change bit by writing 1 to it. A mask register, in which 1 means masked, decides which latched bits reach the interrupt output.

Software reaches the registers through a single-cycle write strobe and a combinational read port. The register addresses are as follows:
- 0x00: poll configuration.
- 0x01: change status.
- 0x02: mask.
- 0x08+p: control word of port p.
- 0x10+p: status word of port p, read-only, in bits 3:0.

Top module: `linkpoll_top`

## Requirements
- R1: After reset the block is in this state: every status word reads 0, the change status reads 0, the mask reads 0x7f, `irq_o` is low and `mdio_req_o` is low.
- R2: The poll engine runs while configuration bit 31 is set. It visits every address from the first address (configuration bits 4:0) up to the last address (bits 12:8), then starts again at the first address. At each address it reads PHY register 1, then register 4, then register 5. A request stays up, with address and register unchanged, until it is acknowledged.
- R3: While configuration bit 31 is clear, no new address is started. Clearing the bit lets the current address finish, and after that no request is raised.
- R4: The link bit of the status word is bit 2 of register 1. Duplex and speed come from the AND of registers 4 and 5, taking the first match in this order: bit 8 gives 100 Mb/s full duplex, bit 7 gives 100 Mb/s half duplex, bit 6 gives 10 Mb/s full duplex, and no match gives 10 Mb/s half duplex.
- R5: Status word layout: bit 0 is link, bit 1 is full duplex, bits 3:2 are the speed code (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s). A polled address N in the range 0 to 6 updates port N. Any other address is polled but stored nowhere.
- R6: When control bit 15 of a port is set, that port's status word equals control bits 3:0. When bit 15 is clear, the status word shows the last polled result again.
- R7: A port's change bit (change status bit = port number) is set whenever the link bit of its status word changes, whether the cause is polling or forcing. A change of duplex or speed alone sets nothing.
- R8: Change bits are sticky. Writing 1 to a bit at address 0x01 clears it, and writing 0 leaves it as it is.
- R9: `irq_o` is high exactly when some change bit is set and its mask bit (address 0x02, 1 = masked) is clear. A masked bit still latches.
- R10: The configuration register reads back bits 31, 30, 29:24, 12:8 and 4:0. Bit 30 drives `mdio_pre_o` and bits 29:24 drive `mdio_clkdiv_o`. Control bits 14, 13, 4 and 5 drive the port's bit in `port_tx_en_o`, `port_rx_en_o`, `port_txfc_o` and `port_rxfc_o` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mdio_req_o | output | 1 | Management read request |
| mdio_phy_o | output | 5 | PHY address of the request |
| mdio_reg_o | output | 5 | PHY register of the request |
| mdio_ack_i | input | 1 | Read completed, data valid |
| mdio_rdata_i | input | 16 | Read data |
| mdio_pre_o | output | 1 | Preamble enable for the serialiser |
| mdio_clkdiv_o | output | 6 | Clock setting for the serialiser |
| port_tx_en_o | output | 7 | Per-port transmit enable |
| port_rx_en_o | output | 7 | Per-port receive enable |
| port_txfc_o | output | 7 | Per-port transmit flow control enable |
| port_rxfc_o | output | 7 | Per-port receive flow control enable |
| irq_o | output | 1 | Unmasked change interrupt |

## Verification
The assertions assume that the serialiser gives `mdio_ack_i` only while a request is up, as a one-cycle pulse. The bench's PHY model keeps to this: it acknowledges every request after two cycles and never acknowledges otherwise. The sticky-bit property assumes that nothing other than a write to address 0x01 can lower a change bit, so register traffic in the bench goes only through the write task. The engine is always restarted from its idle state so that the expected request order is known in advance.

// File: rtl/linkpoll_pkg.sv
package linkpoll_pkg;
  localparam int PHYW = 5;
  localparam int DW   = 32;
  localparam int CW   = 16;

  typedef struct packed {
    logic [1:0] speed;
    logic       duplex;
    logic       link;
  } lnk_st_t;

  typedef enum logic [1:0] {ST_BMSR, ST_ADV, ST_LPA} step_e;

  localparam logic [PHYW-1:0] PREG_BMSR = 5'd1;
  localparam logic [PHYW-1:0] PREG_ADV  = 5'd4;
  localparam logic [PHYW-1:0] PREG_LPA  = 5'd5;

  localparam logic [1:0] SPD_10  = 2'd0;
  localparam logic [1:0] SPD_100 = 2'd1;

  localparam logic [DW-1:0] CFG_MASK = 32'hFF00_1F1F;
  localparam int CFG_EN    = 31;
  localparam int CFG_PRE   = 30;
  localparam int CTL_FORCE = 15;
  localparam int CTL_TXEN  = 14;
  localparam int CTL_RXEN  = 13;
  localparam int CTL_RXFC  = 5;
  localparam int CTL_TXFC  = 4;
endpackage

// File: rtl/linkpoll_seq.sv
module linkpoll_seq
  import linkpoll_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PHYW-1:0] first_i,
  input  logic [PHYW-1:0] last_i,
  output logic            req_o,
  output logic [PHYW-1:0] phy_o,
  output logic [PHYW-1:0] reg_o,
  input  logic            ack_i,
  input  logic [15:0]     rdata_i,
  output logic            upd_o,
  output logic [PHYW-1:0] upd_phy_o,
  output lnk_st_t         upd_st_o
);
  logic            busy_q;
  step_e           step_q;
  logic [PHYW-1:0] cur_q;
  logic            lnk_q;
  logic [2:0]      adv_q;
  logic [2:0]      common;
  logic            unused_rdata;

  assign unused_rdata = ^{rdata_i[15:9], rdata_i[5:3], rdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= ST_BMSR;
      cur_q  <= '0;
      lnk_q  <= 1'b0;
      adv_q  <= '0;
    end else if (!busy_q) begin
      if (en_i) begin
        busy_q <= 1'b1;
        cur_q  <= first_i;
        step_q <= ST_BMSR;
      end
    end else if (ack_i) begin
      case (step_q)
        ST_BMSR: begin lnk_q <= rdata_i[2]; step_q <= ST_ADV; end
        ST_ADV:  begin adv_q <= rdata_i[8:6]; step_q <= ST_LPA; end
        default: begin
          step_q <= ST_BMSR;
          cur_q  <= (cur_q >= last_i) ? first_i : cur_q + 1'b1;
          if (!en_i) busy_q <= 1'b0;  // stop only at an address boundary
        end
      endcase
    end
  end

  always_comb begin
    case (step_q)
      ST_BMSR: reg_o = PREG_BMSR;
      ST_ADV:  reg_o = PREG_ADV;
      default: reg_o = PREG_LPA;
    endcase
  end

  assign req_o = busy_q;
  assign phy_o = cur_q;

  // highest common ability from advertisement AND partner
  assign common = adv_q & rdata_i[8:6];
  always_comb begin
    upd_st_o.link = lnk_q;
    if (common[2])      begin upd_st_o.speed = SPD_100; upd_st_o.duplex = 1'b1; end
    else if (common[1]) begin upd_st_o.speed = SPD_100; upd_st_o.duplex = 1'b0; end
    else if (common[0]) begin upd_st_o.speed = SPD_10;  upd_st_o.duplex = 1'b1; end
    else                begin upd_st_o.speed = SPD_10;  upd_st_o.duplex = 1'b0; end
  end

  assign upd_o     = busy_q && ack_i && (step_q == ST_LPA);
  assign upd_phy_o = cur_q;
endmodule

// File: rtl/linkpoll_port.sv
module linkpoll_port
  import linkpoll_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [PHYW-1:0] upd_phy_i,
  input  lnk_st_t         upd_st_i,
  input  logic            ctl_wr_i,
  input  logic [CW-1:0]   ctl_wdata_i,
  output logic [CW-1:0]   ctl_o,
  output lnk_st_t         st_o,
  output logic            chg_o
);
  lnk_st_t       polled_q;
  logic [CW-1:0] ctl_q;
  logic          link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      polled_q <= '0;
      ctl_q    <= '0;
      link_q   <= 1'b0;
    end else begin
      if (upd_i && upd_phy_i == PHYW'(IDX)) polled_q <= upd_st_i;
      if (ctl_wr_i) ctl_q <= ctl_wdata_i;
      link_q <= st_o.link;
    end
  end

  assign st_o  = ctl_q[CTL_FORCE] ? lnk_st_t'(ctl_q[3:0]) : polled_q;
  assign chg_o = st_o.link != link_q;
  assign ctl_o = ctl_q;
endmodule

// File: rtl/linkpoll_irq.sv
module linkpoll_irq #(
  parameter int NPORT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] chg_i,
  input  logic             ist_wr_i,
  input  logic             msk_wr_i,
  input  logic [NPORT-1:0] wdata_i,
  output logic [NPORT-1:0] ist_o,
  output logic [NPORT-1:0] msk_o,
  output logic             irq_o
);
  logic [NPORT-1:0] ist_q, msk_q, clr;

  assign clr = ist_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ist_q <= '0;
      msk_q <= '1;
    end else begin
      ist_q <= (ist_q & ~clr) | chg_i;  // a new change wins over a clear
      if (msk_wr_i) msk_q <= wdata_i;
    end
  end

  assign ist_o = ist_q;
  assign msk_o = msk_q;
  assign irq_o = |(ist_q & ~msk_q);
endmodule

// File: rtl/linkpoll_top.sv
module linkpoll_top
  import linkpoll_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int AW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             mdio_req_o,
  output logic [PHYW-1:0]  mdio_phy_o,
  output logic [PHYW-1:0]  mdio_reg_o,
  input  logic             mdio_ack_i,
  input  logic [15:0]      mdio_rdata_i,
  output logic             mdio_pre_o,
  output logic [5:0]       mdio_clkdiv_o,
  output logic [NPORT-1:0] port_tx_en_o,
  output logic [NPORT-1:0] port_rx_en_o,
  output logic [NPORT-1:0] port_txfc_o,
  output logic [NPORT-1:0] port_rxfc_o,
  output logic             irq_o
);
  localparam logic [1:0] GRP_GLB = 2'b00;
  localparam logic [1:0] GRP_CTL = 2'b01;
  localparam logic [1:0] GRP_STA = 2'b10;

  logic [DW-1:0]    cfg_q;
  logic             poll_en;
  logic [1:0]       grp;
  logic [2:0]       sel;
  logic             upd;
  logic [PHYW-1:0]  upd_phy;
  lnk_st_t          upd_st;
  logic [NPORT-1:0] chg, ists_q, mask_q;
  logic [CW-1:0]    ctl [NPORT];
  lnk_st_t          st  [NPORT];
  logic             unused_addr;

  assign grp         = reg_addr_i[4:3];
  assign sel         = reg_addr_i[2:0];
  assign unused_addr = ^reg_addr_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (reg_wr_i && grp == GRP_GLB && sel == 3'd0) cfg_q <= reg_wdata_i & CFG_MASK;
  end

  assign poll_en       = cfg_q[CFG_EN];
  assign mdio_pre_o    = cfg_q[CFG_PRE];
  assign mdio_clkdiv_o = cfg_q[29:24];

  linkpoll_seq u_seq (
    .clk_i, .rst_ni,
    .en_i      (poll_en),
    .first_i   (cfg_q[4:0]),
    .last_i    (cfg_q[12:8]),
    .req_o     (mdio_req_o),
    .phy_o     (mdio_phy_o),
    .reg_o     (mdio_reg_o),
    .ack_i     (mdio_ack_i),
    .rdata_i   (mdio_rdata_i),
    .upd_o     (upd),
    .upd_phy_o (upd_phy),
    .upd_st_o  (upd_st)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    linkpoll_port #(.IDX(p)) u_port (
      .clk_i, .rst_ni,
      .upd_i       (upd),
      .upd_phy_i   (upd_phy),
      .upd_st_i    (upd_st),
      .ctl_wr_i    (reg_wr_i && grp == GRP_CTL && sel == 3'(p)),
      .ctl_wdata_i (reg_wdata_i[CW-1:0]),
      .ctl_o       (ctl[p]),
      .st_o        (st[p]),
      .chg_o       (chg[p])
    );
    assign port_tx_en_o[p] = ctl[p][CTL_TXEN];
    assign port_rx_en_o[p] = ctl[p][CTL_RXEN];
    assign port_txfc_o[p]  = ctl[p][CTL_TXFC];
    assign port_rxfc_o[p]  = ctl[p][CTL_RXFC];
  end

  linkpoll_irq #(.NPORT(NPORT)) u_irq (
    .clk_i, .rst_ni,
    .chg_i    (chg),
    .ist_wr_i (reg_wr_i && grp == GRP_GLB && sel == 3'd1),
    .msk_wr_i (reg_wr_i && grp == GRP_GLB && sel == 3'd2),
    .wdata_i  (reg_wdata_i[NPORT-1:0]),
    .ist_o    (ists_q),
    .msk_o    (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (grp)
      GRP_GLB: begin
        if (sel == 3'd0) reg_rdata_o = cfg_q;
        if (sel == 3'd1) reg_rdata_o = DW'(ists_q);
        if (sel == 3'd2) reg_rdata_o = DW'(mask_q);
      end
      GRP_CTL: if (int'(sel) < NPORT) reg_rdata_o = DW'(ctl[sel]);
      GRP_STA: if (int'(sel) < NPORT) reg_rdata_o = DW'(st[sel]);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/linkpoll_chk.sv
module linkpoll_chk #(
  parameter int NPORT = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mdio_req_o,
  input logic             mdio_ack_i,
  input logic [4:0]       mdio_phy_o,
  input logic [4:0]       mdio_reg_o,
  input logic             poll_en,
  input logic             reg_wr_i,
  input logic [4:0]       reg_addr_i,
  input logic [NPORT-1:0] ists_q,
  input logic [NPORT-1:0] mask_q,
  input logic             irq_o
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && !mdio_ack_i |=> mdio_req_o && $stable(mdio_phy_o) && $stable(mdio_reg_o));

  p_order_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && mdio_ack_i && mdio_reg_o == 5'd1 |=> mdio_req_o && mdio_reg_o == 5'd4);

  p_order_lpa_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && mdio_ack_i && mdio_reg_o == 5'd4 |=>
      mdio_req_o && mdio_reg_o == 5'd5 && $stable(mdio_phy_o));

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdio_req_o && !poll_en |=> !mdio_req_o);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 5'h01) |=> (ists_q & $past(ists_q)) == $past(ists_q));

  p_all_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == {NPORT{1'b1}} |-> !irq_o);
endmodule

bind linkpoll_top linkpoll_chk #(.NPORT(NPORT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdio_req_o (mdio_req_o),
  .mdio_ack_i (mdio_ack_i),
  .mdio_phy_o (mdio_phy_o),
  .mdio_reg_o (mdio_reg_o),
  .poll_en    (poll_en),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .ists_q     (ists_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/linkpoll_top_test.sv
module linkpoll_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CFG = 5'h00, A_IST = 5'h01, A_MSK = 5'h02, A_CTL = 5'h08, A_STA = 5'h10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mdio_req, mdio_ack = 0, mdio_pre, irq;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata = 0;
  logic [5:0]  mdio_clkdiv;
  logic [6:0]  tx_en, rx_en, txfc, rxfc;

  int checks = 0, errs = 0, cyc = 0, wcnt = 0;
  bit done = 0;
  logic [9:0]  exp_q[$];
  logic [15:0] bmsr [32], adv [32], lpa [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  linkpoll_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdio_req_o(mdio_req),
    .mdio_phy_o(mdio_phy), .mdio_reg_o(mdio_reg), .mdio_ack_i(mdio_ack),
    .mdio_rdata_i(mdio_rdata), .mdio_pre_o(mdio_pre), .mdio_clkdiv_o(mdio_clkdiv),
    .port_tx_en_o(tx_en), .port_rx_en_o(rx_en), .port_txfc_o(txfc),
    .port_rxfc_o(rxfc), .irq_o(irq)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // PHY model and scoreboard monitor: ack two cycles after a request
  always @(negedge clk) begin
    mdio_ack = 0;
    if (rst_n && mdio_req) begin
      if (wcnt == 1) begin
        wcnt = 0;
        mdio_ack = 1;
        case (mdio_reg)
          5'd1: mdio_rdata = bmsr[mdio_phy];
          5'd4: mdio_rdata = adv[mdio_phy];
          5'd5: mdio_rdata = lpa[mdio_phy];
          default: mdio_rdata = 16'hffff;
        endcase
        if (exp_q.size() > 0) chk("R2 request order", {mdio_phy, mdio_reg}, exp_q.pop_front());
      end else wcnt++;
    end else wcnt = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog R2 actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(string rq, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(rq, d, exp);
  endtask

  // driver: push expected request stream for a window, then start the engine
  task automatic run_window(int first, int last, int rounds);
    wr(A_CFG, 32'h0500_0000);
    repeat (30) @(negedge clk);
    exp_q.delete();
    for (int r = 0; r < rounds; r++)
      for (int a = first; a <= last; a++) begin
        exp_q.push_back({5'(a), 5'd1});
        exp_q.push_back({5'(a), 5'd4});
        exp_q.push_back({5'(a), 5'd5});
      end
    wr(A_CFG, 32'hC500_0000 | (32'(last) << 8) | 32'(first));
    while (exp_q.size() != 0) @(negedge clk);
    wr(A_CFG, 32'h4500_0000 | (32'(last) << 8) | 32'(first));
    repeat (30) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin bmsr[i] = 0; adv[i] = 0; lpa[i] = 0; end
    bmsr[2] = 16'h0004; adv[2] = 16'h01e1; lpa[2] = 16'h01e1;  // 100 full
    bmsr[3] = 16'h0004; adv[3] = 16'h00e1; lpa[3] = 16'h01e1;  // 100 half
    bmsr[4] = 16'h0000; adv[4] = 16'h0041; lpa[4] = 16'h0041;  // 10 full, down
    bmsr[5] = 16'h0004; adv[5] = 16'h0021; lpa[5] = 16'h0021;  // 10 half
    bmsr[7] = 16'h0004; adv[7] = 16'h01e1; lpa[7] = 16'h01e1;
    bmsr[8] = 16'h0004; adv[8] = 16'h01e1; lpa[8] = 16'h01e1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 req", mdio_req, 0);
    chk_reg("R1 ist", A_IST, 0);
    chk_reg("R1 mask", A_MSK, 32'h7f);
    for (int p = 0; p < 7; p++) chk_reg("R1 status", A_STA + 5'(p), 0);

    // R2 R4 R5 window 2..5, two rounds (wrap)
    wr(A_MSK, 0);
    run_window(2, 5, 2);
    chk_reg("R4 port2 100 full", A_STA + 2, 32'h7);
    chk_reg("R4 port3 100 half", A_STA + 3, 32'h5);
    chk_reg("R4 port4 10 full link down", A_STA + 4, 32'h2);
    chk_reg("R4 port5 10 half", A_STA + 5, 32'h1);
    chk_reg("R5 port0 untouched", A_STA + 0, 0);
    chk_reg("R5 port6 untouched", A_STA + 6, 0);
    chk_reg("R7 change bits", A_IST, 32'h2c);
    chk("R9 irq unmasked", irq, 1);

    // R8 write-1-to-clear
    wr(A_IST, 32'h04);
    chk_reg("R8 clear one bit", A_IST, 32'h28);
    wr(A_IST, 32'h00);
    chk_reg("R8 zero write no effect", A_IST, 32'h28);

    // R9 mask
    wr(A_MSK, 32'h7f);
    @(negedge clk);
    chk("R9 all masked", irq, 0);
    chk_reg("R9 bits kept while masked", A_IST, 32'h28);
    wr(A_MSK, 32'h5f);
    @(negedge clk);
    chk("R9 bit5 unmasked", irq, 1);
    wr(A_MSK, 32'h7d);
    @(negedge clk);
    chk("R9 only clear bit unmasked", irq, 0);
    wr(A_MSK, 0);

    // R3 quiet while disabled
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (mdio_req) seen++; end
      chk("R3 no requests while disabled", seen, 0);
    end
    wr(A_IST, 32'h7f);
    chk_reg("R8 clear all", A_IST, 0);

    // R7 speed-only change vs link drop
    lpa[2] = 16'h0041;
    bmsr[5] = 16'h0000;
    run_window(2, 5, 1);
    chk_reg("R4 port2 now 10 full", A_STA + 2, 32'h3);
    chk_reg("R7 port5 link down", A_STA + 5, 32'h0);
    chk_reg("R7 only link change flagged", A_IST, 32'h20);

    // R6 force
    wr(A_CTL + 6, 32'h800b);
    repeat (2) @(negedge clk);
    chk_reg("R6 port6 forced", A_STA + 6, 32'hb);
    chk_reg("R7 force link up flagged", A_IST, 32'h60);
    wr(A_CTL + 2, 32'h8000);
    repeat (2) @(negedge clk);
    chk_reg("R6 port2 forced down", A_STA + 2, 32'h0);
    chk_reg("R7 forced drop flagged", A_IST, 32'h64);
    wr(A_IST, 32'h7f);
    wr(A_CTL + 2, 32'h0000);
    repeat (2) @(negedge clk);
    chk_reg("R6 force released", A_STA + 2, 32'h3);
    chk_reg("R7 release link up flagged", A_IST, 32'h04);

    // R10 config and control outputs
    chk_reg("R10 cfg readback", A_CFG, 32'h4500_0502);
    chk("R10 preamble", mdio_pre, 1);
    chk("R10 clkdiv", mdio_clkdiv, 6'd5);
    wr(A_CTL + 1, 32'h6030);
    chk_reg("R10 ctl readback", A_CTL + 1, 32'h6030);
    chk("R10 tx_en", tx_en, 7'h02);
    chk("R10 rx_en", rx_en, 7'h02);
    chk("R10 txfc", txfc, 7'h02);
    chk("R10 rxfc", rxfc, 7'h02);
    chk_reg("R6 control without force", A_STA + 1, 0);

    // R5 out-of-range addresses are polled but stored nowhere
    wr(A_IST, 32'h7f);
    run_window(7, 8, 2);
    chk_reg("R5 port0", A_STA + 0, 0);
    chk_reg("R5 port2", A_STA + 2, 32'h3);
    chk_reg("R5 port3", A_STA + 3, 32'h5);
    chk_reg("R5 port6", A_STA + 6, 32'hb);
    chk_reg("R5 no change bits", A_IST, 0);

    done = 1;
    summary();
  end
endmodule